// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block holds the control and flag bits for a small low-speed USB device function that has a control endpoint 0 and two IN-only interrupt endpoints, 1 and 2. A CPU reads and writes these bits over a simple register bus. The packet layer reports each token it decodes as an endpoint number and a token kind. One clock later the block answers with a one-cycle response code. The code tells the packet layer to send data, send a NAK, send a STALL, or stay silent. Endpoints 1 and 2 share one transmit-arm bit, one byte-count field and one transmit-complete flag. Each of them has its own enable bit and its own STALL bit.

The block also keeps event flags. It raises a flag when the host acknowledges a packet on endpoint 1 or 2, when the host acknowledges a packet on endpoint 0, and when endpoint 0 finishes a reception. It also keeps an order flag that marks an endpoint 0 transmission still pending when a reception completes. Finally, it drives a force-K request to the line driver for remote wake-up, and masks that forced K so it is not seen as a host resume.

Register map (8-bit data):
- Address 0: byte count in bits 3:0, transmit arm in bit 4, force resume in bit 5.
- Address 1: endpoint control.
- Address 2: event flags, cleared by writing 1.
- Address 3: reads as 0.

Top module: `usb_ep_handshake`

## Requirements
- R1: After reset, every register reads 0, `force_k` is 0 and `resp_valid` is 0.
- R2: Address 0 holds the byte count in bits 3:0, the transmit-arm bit in bit 4 and the force-resume bit in bit 5. These bits read back as written, and bits 7:6 read 0.
- R3: Address 1 holds STALL for endpoint 1 in bit 0, STALL for endpoint 2 in bit 1, enable for endpoint 1 in bit 2 and enable for endpoint 2 in bit 3. Bit 6 reads the transmit-first flag. Bits 7, 5 and 4 read 0.
- R4: A token strobe on `tok_valid` produces `resp_valid` high for exactly one cycle, in the cycle after the strobe. The response code is 0 for none, 1 for data, 2 for NAK and 3 for STALL.
- R5: The rules for an IN token to endpoint 1 or 2 apply in this order, and the first that matches decides the answer:
  - If the endpoint's enable bit is clear, the answer is none.
  - If its STALL bit is set, the answer is STALL.
  - If the arm bit is 0 or the transmit-complete flag is set, the answer is NAK.
  - Otherwise the answer is data, and `resp_len` carries the byte count.
  - `resp_len` is 0 for every answer other than data on endpoint 1 or 2.
- R6: `tok_kind` is coded 0 for OUT, 1 for IN, 2 for SETUP and 3 for reserved. Any token that is not IN, and any token to endpoint 3, gets the answer none.
- R7: An IN token to endpoint 0 gets data while the endpoint 0 transmit flag is clear, and NAK while it is set.
- R8: The event flags live at address 2, and each becomes visible in the cycle after its event:
  - `host_ack` with `ack_ep` set to 1 or 2 sets the transmit-complete flag in bit 0.
  - `host_ack` with `ack_ep` set to 0 sets the endpoint 0 transmit flag in bit 1.
  - `ep0_rx_done` sets bit 2.
  - Writing 1 to a bit clears it, and writing 0 has no effect. A set in the same cycle as a clear wins.
- R9: `ep0_rx_done` sets the transmit-first flag when the endpoint 0 transmit flag is already set in that cycle. Otherwise it leaves the transmit-first flag unchanged.
- R10: Writing 1 to bit 6 of address 1 clears the transmit-first flag. Writing 0 to bit 6 leaves it unchanged.
- R11: `force_k` follows the force-resume bit. `line_k_seen` sets bit 3 of address 2 only while the force-resume bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tok_valid | input | 1 | Token strobe from the packet layer |
| tok_kind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tok_ep | input | 2 | Endpoint the token addresses |
| host_ack | input | 1 | Host acknowledged the last data packet |
| ack_ep | input | 2 | Endpoint of the acknowledged packet |
| ep0_rx_done | input | 1 | Endpoint 0 SETUP/OUT reception completed |
| line_k_seen | input | 1 | Line receiver sees a resume K state |
| resp_valid | output | 1 | Response code valid, one cycle |
| resp_code | output | 2 | 0 none, 1 data, 2 NAK, 3 STALL |
| resp_len | output | 4 | Byte count for a data answer on endpoint 1 or 2 |
| force_k | output | 1 | Request to drive K onto the data lines |

## Verification
The bench builds the block with its default parameters: two IN endpoints, a 4-bit byte count and a 2-bit address. These settings keep the decision space small enough to cover in full. The bench sweeps every combination of the two enable bits, the two STALL bits, the arm bit and the transmit-complete flag, and issues an IN token to each of the two endpoints for every combination. It changes the byte count with each combination, so that `resp_len` is checked against many values. Separate directed sequences cover the endpoint 0 ordering flag, the collision of a flag set with a software clear, non-IN tokens, and the resume masking.

// File: rtl/usb_ep_pkg.sv
// Shared encodings for the endpoint handshake controller.
// Assumes an 8-bit register bus with at most four addresses.
package usb_ep_pkg;
    typedef enum logic [1:0] {
        RESP_NONE  = 2'd0,
        RESP_DATA  = 2'd1,
        RESP_NAK   = 2'd2,
        RESP_STALL = 2'd3
    } resp_e;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'd0,
        TOK_IN    = 2'd1,
        TOK_SETUP = 2'd2
    } tok_e;

    localparam int DATA_W      = 8;
    localparam int ADDR_TXCTL  = 0;
    localparam int ADDR_EPCTL  = 1;
    localparam int ADDR_FLAGS  = 2;
    localparam int TXFIRST_BIT = 6;

    localparam int FLAG_TXDONE = 0;
    localparam int FLAG_EP0TX  = 1;
    localparam int FLAG_EP0RX  = 2;
    localparam int FLAG_RESUME = 3;
    localparam int NUM_FLAGS   = 4;
endpackage

// File: rtl/usb_ep_regs.sv
// Software-owned control bits and the register read multiplexer.
// Turns writes into clear strobes for the hardware flags.
// Assumes SIZE_W + 2 <= 6 and 2*NUM_IN <= 6, so no field reaches bit 6.
module usb_ep_regs
    import usb_ep_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int SIZE_W = 4,
    parameter int NUM_IN = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic                 txfirst,
    output logic [DATA_W-1:0]    rdata,
    output logic [SIZE_W-1:0]    tx_size,
    output logic                 tx_arm,
    output logic                 force_res,
    output logic [NUM_IN-1:0]    ep_en,
    output logic [NUM_IN-1:0]    ep_stall,
    output logic                 txfirst_clr,
    output logic [NUM_FLAGS-1:0] flag_clr
);
    localparam int ARM_BIT = SIZE_W;
    localparam int RES_BIT = SIZE_W + 1;
    localparam int EN_LO   = NUM_IN;

    logic wr_tx, wr_ep, wr_fl;

    // Address decode for the three writable registers.
    always_comb begin
        wr_tx = wr && (addr == ADDR_W'(ADDR_TXCTL));
        wr_ep = wr && (addr == ADDR_W'(ADDR_EPCTL));
        wr_fl = wr && (addr == ADDR_W'(ADDR_FLAGS));
    end

    // Transmit control: byte count, arm bit and force-resume bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_size   <= '0;
            tx_arm    <= 1'b0;
            force_res <= 1'b0;
        end else if (wr_tx) begin
            tx_size   <= wdata[SIZE_W-1:0];
            tx_arm    <= wdata[ARM_BIT];
            force_res <= wdata[RES_BIT];
        end
    end

    // Endpoint control: per-endpoint enable and STALL bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep_en    <= '0;
            ep_stall <= '0;
        end else if (wr_ep) begin
            ep_stall <= wdata[NUM_IN-1:0];
            ep_en    <= wdata[EN_LO +: NUM_IN];
        end
    end

    // Clear strobes for the flags, which are held in the flags module.
    always_comb begin
        txfirst_clr = wr_ep && wdata[TXFIRST_BIT];
        flag_clr    = wr_fl ? wdata[NUM_FLAGS-1:0] : '0;
    end

    // Read multiplexer; unused bits and unused addresses return 0.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADDR_TXCTL): begin
                rdata[SIZE_W-1:0] = tx_size;
                rdata[ARM_BIT]    = tx_arm;
                rdata[RES_BIT]    = force_res;
            end
            ADDR_W'(ADDR_EPCTL): begin
                rdata[NUM_IN-1:0]      = ep_stall;
                rdata[EN_LO +: NUM_IN] = ep_en;
                rdata[TXFIRST_BIT]     = txfirst;
            end
            ADDR_W'(ADDR_FLAGS): rdata[NUM_FLAGS-1:0] = flags;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/usb_ep_flags.sv
// Hardware event flags and the endpoint 0 transmit-first order flag.
// Each flag is set by an event and cleared by software writing 1.
// A set in the same cycle as a clear wins.
// The order flag looks at the stored endpoint 0 transmit flag,
// not at an acknowledge arriving in the same cycle.
module usb_ep_flags
    import usb_ep_pkg::*;
#(
    parameter int NUM_IN = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_ack,
    input  logic [1:0]           ack_ep,
    input  logic                 ep0_rx_done,
    input  logic                 line_k_seen,
    input  logic                 force_res,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    input  logic                 txfirst_clr,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 txfirst
);
    logic [NUM_FLAGS-1:0] flag_set;
    logic                 first_set;

    // Event decode into per-flag set requests.
    always_comb begin
        flag_set              = '0;
        flag_set[FLAG_TXDONE] = host_ack && (ack_ep != 2'd0) && (int'(ack_ep) <= NUM_IN);
        flag_set[FLAG_EP0TX]  = host_ack && (ack_ep == 2'd0);
        flag_set[FLAG_EP0RX]  = ep0_rx_done;
        flag_set[FLAG_RESUME] = line_k_seen && !force_res;
        first_set             = ep0_rx_done && flags[FLAG_EP0TX];
    end

    // Flag storage: the set request takes priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags   <= '0;
            txfirst <= 1'b0;
        end else begin
            flags   <= (flags & ~flag_clr) | flag_set;
            txfirst <= (txfirst & ~txfirst_clr) | first_set;
        end
    end
endmodule

// File: rtl/usb_ep_decide.sv
// Handshake decision: one registered response per token strobe.
// For endpoints 1..NUM_IN the first matching rule wins:
// disabled gives none, then STALL, then NAK, then data.
// Endpoint 0 answers an IN token with data, or with NAK while its
// transmit flag is set. Tokens that are not IN get no answer.
module usb_ep_decide
    import usb_ep_pkg::*;
#(
    parameter int SIZE_W = 4,
    parameter int NUM_IN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [1:0]        tok_ep,
    input  logic [NUM_IN-1:0] ep_en,
    input  logic [NUM_IN-1:0] ep_stall,
    input  logic              tx_arm,
    input  logic              txdone,
    input  logic              ep0_busy,
    input  logic [SIZE_W-1:0] tx_size,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic [SIZE_W-1:0] resp_len
);
    localparam int NUM_EP = NUM_IN + 1;

    logic [2*NUM_EP-1:0] codes;
    resp_e               nxt_code;
    logic [SIZE_W-1:0]   nxt_len;

    // Endpoint 0 candidate answer.
    assign codes[1:0] = ep0_busy ? RESP_NAK : RESP_DATA;

    // Candidate answer for each IN endpoint.
    for (genvar i = 0; i < NUM_IN; i++) begin : g_ep
        assign codes[2*(i+1) +: 2] = !ep_en[i]             ? RESP_NONE  :
                                     ep_stall[i]           ? RESP_STALL :
                                     (!tx_arm || txdone)   ? RESP_NAK   :
                                                             RESP_DATA;
    end

    // Select the candidate for the addressed endpoint.
    always_comb begin
        nxt_code = RESP_NONE;
        nxt_len  = '0;
        if (tok_kind == TOK_IN && int'(tok_ep) < NUM_EP) begin
            nxt_code = resp_e'(codes[2*int'(tok_ep) +: 2]);
            if (nxt_code == RESP_DATA && tok_ep != 2'd0) begin
                nxt_len = tx_size;
            end
        end
    end

    // Response register: holds the answer for one cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RESP_NONE;
            resp_len   <= '0;
        end else begin
            resp_valid <= tok_valid;
            resp_code  <= tok_valid ? nxt_code : RESP_NONE;
            resp_len   <= tok_valid ? nxt_len : '0;
        end
    end
endmodule

// File: rtl/usb_ep_handshake.sv
// Top of the endpoint handshake controller. Connects the register file,
// the event flags and the decision logic.
// Assumes tokens and acknowledges arrive as single-cycle strobes.
module usb_ep_handshake
    import usb_ep_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int SIZE_W = 4,
    parameter int NUM_IN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [1:0]        tok_ep,
    input  logic              host_ack,
    input  logic [1:0]        ack_ep,
    input  logic              ep0_rx_done,
    input  logic              line_k_seen,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic [SIZE_W-1:0] resp_len,
    output logic              force_k
);
    logic [SIZE_W-1:0]    tx_size;
    logic                 tx_arm, force_res, txfirst, txfirst_clr;
    logic [NUM_IN-1:0]    ep_en, ep_stall;
    logic [NUM_FLAGS-1:0] flag_q, flag_clr;
    logic                 txdone, ep0_tx, resume_flag;

    // Named views of the individual flag bits.
    assign txdone      = flag_q[FLAG_TXDONE];
    assign ep0_tx      = flag_q[FLAG_EP0TX];
    assign resume_flag = flag_q[FLAG_RESUME];
    assign force_k     = force_res;

    usb_ep_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .NUM_IN(NUM_IN)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .flags(flag_q), .txfirst(txfirst), .rdata(bus_rdata),
        .tx_size(tx_size), .tx_arm(tx_arm), .force_res(force_res),
        .ep_en(ep_en), .ep_stall(ep_stall),
        .txfirst_clr(txfirst_clr), .flag_clr(flag_clr)
    );

    usb_ep_flags #(.NUM_IN(NUM_IN)) u_flags (
        .clk(clk), .rst_n(rst_n), .host_ack(host_ack), .ack_ep(ack_ep),
        .ep0_rx_done(ep0_rx_done), .line_k_seen(line_k_seen),
        .force_res(force_res), .flag_clr(flag_clr), .txfirst_clr(txfirst_clr),
        .flags(flag_q), .txfirst(txfirst)
    );

    usb_ep_decide #(.SIZE_W(SIZE_W), .NUM_IN(NUM_IN)) u_decide (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .tok_ep(tok_ep), .ep_en(ep_en), .ep_stall(ep_stall), .tx_arm(tx_arm),
        .txdone(txdone), .ep0_busy(ep0_tx), .tx_size(tx_size),
        .resp_valid(resp_valid), .resp_code(resp_code), .resp_len(resp_len)
    );
endmodule

// File: rtl/usb_ep_handshake_chk.sv
// Property checker for usb_ep_handshake, attached with bind.
// Observes top-level ports and the internal register and flag values.
module usb_ep_handshake_chk #(
    parameter int NUM_IN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic [1:0]        tok_ep,
    input logic              resp_valid,
    input logic [1:0]        resp_code,
    input logic              tx_arm,
    input logic              txdone,
    input logic [NUM_IN-1:0] ep_stall,
    input logic              host_ack,
    input logic [1:0]        ack_ep,
    input logic              ep0_rx_done,
    input logic              ep0_tx,
    input logic              txfirst,
    input logic              resume_flag,
    input logic              force_k,
    input logic [1:0]        bus_addr,
    input logic [7:0]        bus_rdata
);
    localparam logic [7:0] EPCTL_RSV =
        ~((8'd1 << 6) | ((8'd1 << (2*NUM_IN)) - 8'd1));

    // R4: a response appears only in the cycle after a token strobe.
    assert_resp_follows_tok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(tok_valid));

    // R4: every token strobe is answered in the next cycle.
    assert_tok_answered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |=> resp_valid);

    // R5: a STALL answer needs a nonzero endpoint and a STALL bit set.
    assert_stall_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd3) |-> ($past(tok_ep) != 2'd0 && $past(|ep_stall)));

    // R5: data on endpoints 1 or 2 needs the arm bit set and the complete flag clear.
    assert_data_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd1 && $past(tok_ep) != 2'd0) |-> ($past(tx_arm) && !$past(txdone)));

    // R8: an acknowledge on endpoint 1 raises the transmit-complete flag.
    assert_txdone_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && ack_ep == 2'd1) |=> txdone);

    // R9: the order flag rises only on a reception while endpoint 0 transmit is pending.
    assert_txfirst_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txfirst) |-> $past(ep0_rx_done && ep0_tx));

    // R11: the resume flag never rises while K is being forced.
    assert_no_self_resume_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_flag) |-> !$past(force_k));

    // R3: unimplemented endpoint-control bits read 0.
    assert_epctl_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd1) |-> ((bus_rdata & EPCTL_RSV) == 8'd0));
endmodule

bind usb_ep_handshake usb_ep_handshake_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ep(tok_ep),
    .resp_valid(resp_valid), .resp_code(resp_code), .tx_arm(tx_arm),
    .txdone(txdone), .ep_stall(ep_stall), .host_ack(host_ack), .ack_ep(ack_ep),
    .ep0_rx_done(ep0_rx_done), .ep0_tx(ep0_tx), .txfirst(txfirst),
    .resume_flag(resume_flag), .force_k(force_k), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/usb_ep_handshake_tb.sv
module usb_ep_handshake_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = '0;
    logic [1:0] tok_ep = '0;
    logic       host_ack = 1'b0;
    logic [1:0] ack_ep = '0;
    logic       ep0_rx_done = 1'b0;
    logic       line_k_seen = 1'b0;
    logic       resp_valid;
    logic [1:0] resp_code;
    logic [3:0] resp_len;
    logic       force_k;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    usb_ep_handshake u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tok_valid(tok_valid),
        .tok_kind(tok_kind), .tok_ep(tok_ep), .host_ack(host_ack), .ack_ep(ack_ep),
        .ep0_rx_done(ep0_rx_done), .line_k_seen(line_k_seen),
        .resp_valid(resp_valid), .resp_code(resp_code), .resp_len(resp_len),
        .force_k(force_k)
    );

    always #5ns clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles=%0d expected finish earlier", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 2'(a);
        bus_wdata = 8'(d);
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string req);
        @(negedge clk);
        bus_addr = 2'(a);
        #1ns;
        chk(req, int'(bus_rdata), exp);
    endtask

    // Issue one token; check the one-cycle answer and its length.
    task automatic tok(input int kind, input int ep, input int exp_code,
                       input int exp_len, input string req);
        @(negedge clk);
        tok_valid = 1'b1;
        tok_kind = 2'(kind);
        tok_ep = 2'(ep);
        @(negedge clk);
        tok_valid = 1'b0;
        chk({req, " valid"}, int'(resp_valid), 1);
        chk({req, " code"}, int'(resp_code), exp_code);
        chk({req, " len"}, int'(resp_len), exp_len);
        @(negedge clk);
        chk("R4 one-cycle", int'(resp_valid), 0);
    endtask

    task automatic ack(input int ep);
        @(negedge clk);
        host_ack = 1'b1;
        ack_ep = 2'(ep);
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    task automatic rx0();
        @(negedge clk);
        ep0_rx_done = 1'b1;
        @(negedge clk);
        ep0_rx_done = 1'b0;
    endtask

    task automatic kpulse();
        @(negedge clk);
        line_k_seen = 1'b1;
        @(negedge clk);
        line_k_seen = 1'b0;
    endtask

    // Reference model of the R5 decision for endpoints 1 and 2.
    function automatic int exp_in(input bit en, input bit st, input bit arm, input bit done);
        if (!en) return 0;
        if (st) return 3;
        if (!arm || done) return 2;
        return 1;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, 0, "R1 txctl");
        rd(1, 0, "R1 epctl");
        rd(2, 0, "R1 flags");
        rd(3, 0, "R1 addr3");
        chk("R1 force_k", int'(force_k), 0);
        chk("R1 resp_valid", int'(resp_valid), 0);

        // R2 transmit control readback
        wr(0, 8'hFF);
        rd(0, 8'h3F, "R2 txctl all ones");
        wr(0, 8'h19);
        rd(0, 8'h19, "R2 txctl pattern");

        // R3 endpoint control readback
        wr(1, 8'hFF);
        rd(1, 8'h0F, "R3 epctl all ones");
        wr(1, 8'h0C);
        rd(1, 8'h0C, "R3 epctl enables");

        // R6 non-IN tokens and endpoint 3 (ep1/2 enabled, armed)
        tok(0, 1, 0, 0, "R6 OUT ep1");
        tok(2, 2, 0, 0, "R6 SETUP ep2");
        tok(3, 1, 0, 0, "R6 reserved ep1");
        tok(1, 3, 0, 0, "R6 IN ep3");
        tok(1, 1, 1, 9, "R5 IN ep1 data");

        // R7 endpoint 0 IN and R8 ep0 transmit flag
        tok(1, 0, 1, 0, "R7 ep0 idle data");
        ack(0);
        rd(2, 8'h02, "R8 ep0 tx flag");
        tok(1, 0, 2, 0, "R7 ep0 busy NAK");
        tok(0, 0, 0, 0, "R6 ep0 OUT none");

        // R9 order flag, R10 its clear
        rx0();
        rd(1, 8'h4C, "R9 txfirst set");
        rd(2, 8'h06, "R8 ep0 rx flag");
        wr(1, 8'h0C);
        rd(1, 8'h4C, "R10 write 0 keeps");
        wr(1, 8'h4C);
        rd(1, 8'h0C, "R10 write 1 clears");
        wr(2, 8'h00);
        rd(2, 8'h06, "R8 write 0 keeps");
        wr(2, 8'h06);
        rd(2, 8'h00, "R8 W1C clears");
        rx0();
        rd(1, 8'h0C, "R9 no set when tx clear");
        wr(2, 8'h04);

        // R8 set collides with a software clear: the set wins
        @(negedge clk);
        host_ack = 1'b1;
        ack_ep = 2'd2;
        bus_addr = 2'd2;
        bus_wdata = 8'h01;
        bus_wr = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        bus_wr = 1'b0;
        rd(2, 8'h01, "R8 set beats clear");
        wr(2, 8'h01);
        rd(2, 8'h00, "R8 txdone cleared");

        // R11 forced K masks the resume flag
        wr(0, 8'h20);
        chk("R11 force_k on", int'(force_k), 1);
        kpulse();
        rd(2, 8'h00, "R11 masked while forcing");
        wr(0, 8'h00);
        chk("R11 force_k off", int'(force_k), 0);
        kpulse();
        rd(2, 8'h08, "R11 resume seen");
        wr(2, 8'h08);

        // R5 full sweep: en1, en2, stall1, stall2, arm, txdone
        for (int cfg = 0; cfg < 64; cfg++) begin
            bit s1, s2, e1, e2, arm, done;
            int sz;
            s1 = cfg[0]; s2 = cfg[1]; e1 = cfg[2]; e2 = cfg[3];
            arm = cfg[4]; done = cfg[5];
            sz = (cfg * 7 + 3) % 16;
            wr(1, int'({4'b0, e2, e1, s2, s1}));
            wr(0, int'({3'b0, arm, 4'(sz)}));
            if (done) ack(1);
            else wr(2, 8'h01);
            for (int ep = 1; ep <= 2; ep++) begin
                int c;
                c = (ep == 1) ? exp_in(e1, s1, arm, done) : exp_in(e2, s2, arm, done);
                tok(1, ep, c, (c == 1) ? sz : 0, "R5 sweep");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule